// File: doc/BRIEF.md
# Double-Buffered Serial Byte Receiver

This block receives asynchronous serial characters and passes each one to software through a two-level structure. The first level turns the oversampled line into a parallel byte. The second level holds the finished byte for software, which reads it through a data port. A ready flag announces each new byte. Overrun and framing error bits travel with the byte they describe.

Software consumes a byte in one of two ways. It can pulse the read strobe, which frees the holding level. It can also discard the byte without reading it, by writing a one to the flag-clear port. If the holding level is still occupied when the next character completes, the new character overwrites the old one and its overrun bit is set. The line is sampled on a tick that runs at sixteen times the baud rate. A low pulse that has ended by the middle of the start bit is rejected as noise.

Top module: `uart_rx_dbuf`

## Requirements
- R1: A frame is one low start bit, 8 data bits with the least significant bit first, then one stop bit, each bit 16 ticks of `os_tick` long. Once the stop bit is sampled, the byte appears on `rx_data` and `rx_ready` goes to 1.
- R2: A low level on `rx_line` that has returned high by the 8th tick after it was first seen is ignored. No byte is produced, and `rx_ready` and `rx_data` keep their values.
- R3: A one-cycle pulse on `rd_pulse` clears `rx_ready`, `ovr_err` and `frm_err` in the next cycle, while `rx_data` keeps the byte.
- R4: A cycle with `flag_we`=1 and `flag_wdata`=1 discards the held byte: `rx_ready`, `ovr_err` and `frm_err` become 0. With `flag_wdata`=0 the write has no effect.
- R5: When a character completes while `rx_ready` is 1 and no read or discard falls in that cycle, the new byte replaces the held byte and `ovr_err` becomes 1.
- R6: When the stop bit is sampled low, `frm_err` becomes 1 and the byte is still delivered with `rx_ready`=1. A high stop bit gives `frm_err`=0.
- R7: A read or discard in the same cycle as a character's completion frees the old byte first. The new byte is held with `rx_ready`=1 and `ovr_err`=0.
- R8: After reset, `rx_ready`, `ovr_err`, `frm_err` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle strobe at 16x the baud rate |
| rd_pulse | input | 1 | Data-register read strobe, frees the holding level |
| flag_we | input | 1 | Write strobe for the ready flag |
| flag_wdata | input | 1 | Write data for the ready flag; 1 discards the held byte |
| rx_data | output | 8 | Held byte |
| rx_ready | output | 1 | A byte is held and has not been read or discarded |
| ovr_err | output | 1 | The held byte overwrote an unread byte |
| frm_err | output | 1 | The held byte had a low stop bit |

## Verification
A character can complete in the same cycle that software reads or discards the previous one. The block must then treat the old byte as consumed, not as overwritten. To provoke this, the bench first sends a frame into an empty receiver and counts the cycles until `rx_ready` rises. Frames always start at the same tick phase, so that count is fixed. The bench then fills the holding level, sends a second frame, and places the read pulse, or in another run the clear write, exactly in the completion cycle. The result counts as correct when the second byte is held with the ready flag set and no overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              tick,
  output logic              done,
  output logic [DATA_W-1:0] byte_out,
  output logic              stop_bad
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  nbit;
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      nbit     <= '0;
      sr       <= '0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!line) state <= RX_START;
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              nbit <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt <= '0;
              sr  <= {line, sr[DATA_W-1:1]};
              if (nbit == TOP) state <= RX_STOP;
              else             nbit  <= nbit + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              done     <= 1'b1;
              stop_bad <= !line;
              state    <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_out = sr;

  // R2
  glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tick && cnt == MID && line) |=> (state == RX_IDLE && !done));

  // R1
  done_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == RX_STOP));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              load_ferr,
  input  logic              rd,
  input  logic              discard,
  output logic [DATA_W-1:0] hold_byte,
  output logic              ready,
  output logic              ovr,
  output logic              frm
);
  logic release_now;
  assign release_now = rd | discard;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte <= '0;
      ready     <= 1'b0;
      ovr       <= 1'b0;
      frm       <= 1'b0;
    end else if (load) begin
      hold_byte <= load_byte;
      ready     <= 1'b1;
      ovr       <= ready & ~release_now;
      frm       <= load_ferr;
    end else if (release_now) begin
      ready <= 1'b0;
      ovr   <= 1'b0;
      frm   <= 1'b0;
    end
  end

  // R1
  ready_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> ready);

  // R3
  read_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !load) |=> (!ready && !ovr && !frm && $stable(hold_byte)));

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (load && ready && !release_now) |=> ovr);

  // R7
  same_cycle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (load && release_now) |=> (ready && !ovr));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !release_now) |=> ($stable(hold_byte) && $stable(ready)));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              rd_pulse,
  input  logic              flag_we,
  input  logic              flag_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              ovr_err,
  output logic              frm_err
);
  logic              line_s;
  logic              done;
  logic [DATA_W-1:0] shifted;
  logic              stop_bad;
  logic              discard;

  assign discard = flag_we & flag_wdata;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_rx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .line     (line_s),
    .tick     (os_tick),
    .done     (done),
    .byte_out (shifted),
    .stop_bad (stop_bad)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (done),
    .load_byte (shifted),
    .load_ferr (stop_bad),
    .rd        (rd_pulse),
    .discard   (discard),
    .hold_byte (rx_data),
    .ready     (rx_ready),
    .ovr       (ovr_err),
    .frm       (frm_err)
  );

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_ready && !ovr_err && !frm_err && rx_data == '0));
endmodule

// File: tb/uart_rx_dbuf_test.sv
module uart_rx_dbuf_test;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       rd_pulse = 1'b0;
  logic       flag_we = 1'b0;
  logic       flag_wdata = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, ovr_err, frm_err;

  int n_run = 0;
  int n_fail = 0;
  int tdiv = 0;
  int lat = 0;
  int e_ready = 0, e_data = 0, e_ovr = 0, e_frm = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    os_tick <= (tdiv == 3);
    tdiv    <= (tdiv + 1) % 4;
  end

  uart_rx_dbuf uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
    .rd_pulse(rd_pulse), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err), .frm_err(frm_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_bit(input int b, input int stop_ok, input int idx);
    if (idx == 0) return 0;
    if (idx == 9) return stop_ok;
    return (b >> (idx - 1)) & 1;
  endfunction

  task automatic check_all(input string req);
    check({req, " ready"}, int'(rx_ready), e_ready);
    check({req, " data"},  int'(rx_data),  e_data);
    check({req, " ovr"},   int'(ovr_err),  e_ovr);
    check({req, " frm"},   int'(frm_err),  e_frm);
  endtask

  // act_kind: 0 read pulse, 1 flag-clear write; act_at < 0 means no action
  task automatic send_frame(input int b, input int stop_ok, input int act_at,
                            input int act_kind, output int first_hi);
    first_hi = -1;
    do @(negedge clk); while (tdiv != 0);
    for (int i = 0; i < 10 * BITCLK; i++) begin
      if (i != 0) @(negedge clk);
      if (first_hi < 0 && rx_ready) first_hi = i;
      rx_line    = frame_bit(b, stop_ok, i / BITCLK)[0];
      rd_pulse   = (i == act_at && act_kind == 0);
      flag_we    = (i == act_at && act_kind == 1);
      flag_wdata = (i == act_at && act_kind == 1);
    end
    @(negedge clk);
    rx_line = 1'b1; rd_pulse = 1'b0; flag_we = 1'b0; flag_wdata = 1'b0;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic model_load(input int b, input int stop_ok);
    e_ovr = e_ready; e_ready = 1; e_data = b; e_frm = (stop_ok == 0);
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    check({req, " read value"}, int'(rx_data), e_data);
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
    e_ready = 0; e_ovr = 0; e_frm = 0;
    check_all(req);
  endtask

  task automatic do_clear(input int wd, input string req);
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = wd[0];
    @(negedge clk);
    flag_we = 1'b0; flag_wdata = 1'b0;
    if (wd != 0) begin e_ready = 0; e_ovr = 0; e_frm = 0; end
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R8 reset");

    // R1 basic frame into empty holding stage; measure latency
    send_frame(8'hA5, 1, -1, 0, lat);
    model_load(8'hA5, 1);
    check_all("R1 first frame");
    lat = lat;
    do_read("R3 read after first");

    // R2 short low pulse is noise
    @(negedge clk);
    rx_line = 1'b0;
    repeat (20) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check_all("R2 glitch rejected");

    // R6 framing error
    send_frame(8'h3C, 0, -1, 0, k);
    model_load(8'h3C, 0);
    check_all("R6 bad stop");
    do_read("R3 read clears frm");

    // R5 overrun
    send_frame(8'h11, 1, -1, 0, k);
    model_load(8'h11, 1);
    send_frame(8'hE2, 1, -1, 0, k);
    model_load(8'hE2, 1);
    check_all("R5 overrun");
    do_clear(0, "R4 write zero ignored");
    do_clear(1, "R4 discard");

    // R7 read in completion cycle
    send_frame(8'h55, 1, -1, 0, k);
    model_load(8'h55, 1);
    send_frame(8'h9B, 1, lat - 1, 0, k);
    e_ready = 1; e_data = 8'h9B; e_ovr = 0; e_frm = 0;
    check_all("R7 read collide");
    // R7 discard in completion cycle
    send_frame(8'h07, 1, lat - 1, 1, k);
    e_ready = 1; e_data = 8'h07; e_ovr = 0; e_frm = 0;
    check_all("R7 clear collide");
    do_read("R3 read after collide");

    // random traffic: R1 R3 R4 R5 R6
    for (int it = 0; it < 40; it++) begin
      int b, ok, act;
      b  = int'($urandom % 256);
      ok = ($urandom % 6 == 0) ? 0 : 1;
      send_frame(b, ok, -1, 0, k);
      model_load(b, ok);
      check_all("R1/R5/R6 random frame");
      act = int'($urandom % 4);
      if (act == 0)      do_read("R3 random read");
      else if (act == 1) do_clear(1, "R4 random discard");
      else if (act == 2) do_clear(0, "R4 random zero write");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule